// File: doc/BRIEF.md
# RMII Receive Byte Assembler

This block sits on the MAC side of a reduced media-independent interface and turns the two-bit receive stream into bytes. It runs on the 50 MHz reference clock and samples the carrier/data-valid strobe, the receive dibit and the receive error line on every rising edge. While carrier is present it skips the zero dibits that appear before the PHY's decoder settles. It also skips the preamble. It locks byte alignment on the tail of the start-of-frame delimiter and then packs each group of four dibits into one byte.

The byte stream comes out with a one-cycle valid strobe. Each completed byte is held back until the block knows whether another byte follows, so the final byte can carry a last flag. The last byte also carries two flags: a sticky receive-error flag gathered over the whole carrier period, and an alignment-error flag that is set when carrier drops part-way through a byte.

Top module: `rmii_rx_deser`

## Requirements
- R1: While reset is held and right after it is released, out_valid_o, out_last_o, out_err_o and out_align_o are 0.
- R2: Dibits received with carrier before alignment is locked are discarded. This covers leading 00 dibits and preamble 01 dibits. No byte is emitted before the lock.
- R3: Alignment locks when a dibit 01 is directly followed by a dibit 11 while carrier is high. The next dibit fills bits [1:0] of the first byte, and the following three fill [3:2], [5:4] and [7:6].
- R4: A completed byte is emitted, with out_valid_o high for one cycle and out_last_o low, in the cycle after the next byte completes, as long as carrier is still high.
- R5: The last complete byte of a frame is emitted with out_valid_o and out_last_o high in the cycle after the first clock edge that samples crs_dv_i low.
- R6: If carrier drops while 1 to 3 dibits of a further byte have been collected, out_align_o is 1 together with the last byte. Otherwise out_align_o is 0. The partial byte is dropped, and a frame with no complete byte emits nothing.
- R7: A high rx_er_i on any edge where crs_dv_i is high, from the first dibit of carrier onward, sets a sticky flag. The flag appears as out_err_o with the last byte and is cleared when the next carrier period begins.
- R8: rx_er_i sampled while crs_dv_i is low has no effect on out_err_o.
- R9: rxd_i sampled while crs_dv_i is low is ignored. Nonzero values there neither start a frame nor change any output.
- R10: A carrier period that ends before the 01-then-11 lock emits no byte. A dibit other than 01 between preamble dibits and 11 prevents the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz receive reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| crs_dv_i | input | 1 | Carrier sense / receive data valid |
| rxd_i | input | 2 | Receive dibit |
| rx_er_i | input | 1 | Receive error from the PHY |
| out_valid_o | output | 1 | One-cycle strobe for out_data_o |
| out_data_o | output | 8 | Assembled byte |
| out_last_o | output | 1 | Marks the final byte of a frame |
| out_err_o | output | 1 | Receive error seen during the frame, valid with last |
| out_align_o | output | 1 | Frame ended on a partial byte, valid with last |

## Verification
The assertions check, on every cycle, the timing rules that tie the output strobe to the carrier line. A last byte only follows a clock edge that sampled carrier low, and a non-last byte only follows an edge that sampled it high. The error flags never appear without the last flag, and nothing is emitted after two idle samples. The bench's frame sweeps are what show the rest: skipping zeros and preamble, placing dibits in bytes least significant pair first, raising the alignment error for every partial length, and scoping the sticky error to carrier-high cycles. The assertions only see flag timing, not byte contents or the frame-scoped error.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HUNT = 2'd1,
        ST_DATA = 2'd2
    } rx_state_e;

    localparam logic [1:0] PRE_DIBIT = 2'b01;
    localparam logic [1:0] SFD_TAIL  = 2'b11;

endpackage

// File: rtl/rmii_sfd_detect.sv
module rmii_sfd_detect
    import rmii_rx_pkg::*;
(
    input  logic       seen_pre_i,
    input  logic [1:0] dibit_i,
    output logic       seen_pre_o,
    output logic       lock_o
);

    // The delimiter tail counts only right after a preamble dibit.
    always_comb begin
        seen_pre_o = (dibit_i == PRE_DIBIT);
        lock_o     = seen_pre_i && (dibit_i == SFD_TAIL);
    end

endmodule

// File: rtl/rmii_dibit_place.sv
module rmii_dibit_place #(
    parameter int BYTE_W = 8,
    localparam int SLOTS = BYTE_W / 2,
    localparam int CNT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic [BYTE_W-1:0] word_i,
    input  logic [CNT_W-1:0]  slot_i,
    input  logic [1:0]        dibit_i,
    output logic [BYTE_W-1:0] word_o,
    output logic              full_o
);

    // Slot k holds bits [2k+1:2k]; the first dibit lands in the low pair.
    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        assign word_o[2*k +: 2] = (slot_i == CNT_W'(k)) ? dibit_i : word_i[2*k +: 2];
    end

    assign full_o = (slot_i == CNT_W'(SLOTS - 1));

endmodule

// File: rtl/rmii_rx_deser.sv
module rmii_rx_deser
    import rmii_rx_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              crs_dv_i,
    input  logic [1:0]        rxd_i,
    input  logic              rx_er_i,
    output logic              out_valid_o,
    output logic [BYTE_W-1:0] out_data_o,
    output logic              out_last_o,
    output logic              out_err_o,
    output logic              out_align_o
);

    localparam int SLOTS = BYTE_W / 2;
    localparam int CNT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    typedef struct packed {
        rx_state_e         state;
        logic              seen_pre;
        logic [CNT_W-1:0]  slot;
        logic [BYTE_W-1:0] shreg;
        logic [BYTE_W-1:0] hold;
        logic              hold_vld;
        logic              err;
        logic              ov;
        logic [BYTE_W-1:0] od;
        logic              ol;
        logic              oe;
        logic              oa;
    } regs_t;

    regs_t q, d;

    logic              seen_nx;
    logic              lock;
    logic [BYTE_W-1:0] placed;
    logic              full;

    rmii_sfd_detect u_sfd (
        .seen_pre_i (q.seen_pre),
        .dibit_i    (rxd_i),
        .seen_pre_o (seen_nx),
        .lock_o     (lock)
    );

    rmii_dibit_place #(.BYTE_W(BYTE_W)) u_place (
        .word_i  (q.shreg),
        .slot_i  (q.slot),
        .dibit_i (rxd_i),
        .word_o  (placed),
        .full_o  (full)
    );

    always_comb begin
        d    = q;
        d.ov = 1'b0;
        d.ol = 1'b0;
        d.oe = 1'b0;
        d.oa = 1'b0;

        if (crs_dv_i) begin
            // First carrier sample restarts the sticky error flag.
            if (q.state == ST_IDLE) begin
                d.err = rx_er_i;
            end else begin
                d.err = q.err | rx_er_i;
            end

            if (q.state != ST_DATA) begin
                d.seen_pre = seen_nx;
                d.slot     = '0;
                d.state    = lock ? ST_DATA : ST_HUNT;
            end else begin
                d.shreg = placed;
                if (full) begin
                    d.slot     = '0;
                    d.hold     = placed;
                    d.hold_vld = 1'b1;
                    if (q.hold_vld) begin
                        d.ov = 1'b1;
                        d.od = q.hold;
                    end
                end else begin
                    d.slot = q.slot + CNT_W'(1);
                end
            end
        end else begin
            // Carrier gone: flush the held byte as the frame's last one.
            if (q.state == ST_DATA && q.hold_vld) begin
                d.ov = 1'b1;
                d.od = q.hold;
                d.ol = 1'b1;
                d.oe = q.err;
                d.oa = (q.slot != '0);
            end
            d.state    = ST_IDLE;
            d.seen_pre = 1'b0;
            d.slot     = '0;
            d.shreg    = '0;
            d.hold_vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign out_valid_o = q.ov;
    assign out_data_o  = q.od;
    assign out_last_o  = q.ol;
    assign out_err_o   = q.oe;
    assign out_align_o = q.oa;

endmodule

// File: rtl/rmii_rx_deser_chk.sv
module rmii_rx_deser_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              crs_dv_i,
    input logic [1:0]        rxd_i,
    input logic              rx_er_i,
    input logic              out_valid_o,
    input logic [BYTE_W-1:0] out_data_o,
    input logic              out_last_o,
    input logic              out_err_o,
    input logic              out_align_o
);

    assert_last_is_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_last_o |-> out_valid_o);

    assert_last_after_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_last_o |-> !$past(crs_dv_i));

    assert_mid_byte_with_carrier_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_last_o) |-> $past(crs_dv_i));

    assert_flags_on_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_align_o || out_err_o) |-> out_last_o);

    assert_quiet_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(crs_dv_i) && !$past(crs_dv_i, 2)) |-> !out_valid_o);

endmodule

bind rmii_rx_deser rmii_rx_deser_chk #(.BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/sim_rmii_rx_deser.sv
module sim_rmii_rx_deser;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       crs = 1'b0;
    logic [1:0] rxd = 2'b00;
    logic       rxer = 1'b0;

    logic       ov;
    logic [7:0] od;
    logic       ol, oe, oa;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [7:0] cap_d [0:4095];
    logic       cap_l [0:4095];
    logic       cap_e [0:4095];
    logic       cap_a [0:4095];
    int         cap_n = 0;

    always #5 clk = ~clk;

    rmii_rx_deser u0 (
        .clk(clk), .rst_n(rst_n), .crs_dv_i(crs), .rxd_i(rxd), .rx_er_i(rxer),
        .out_valid_o(ov), .out_data_o(od), .out_last_o(ol),
        .out_err_o(oe), .out_align_o(oa)
    );

    always @(negedge clk) begin
        if (rst_n && ov && cap_n < 4096) begin
            cap_d[cap_n] = od;
            cap_l[cap_n] = ol;
            cap_e[cap_n] = oe;
            cap_a[cap_n] = oa;
            cap_n = cap_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic c, input logic [1:0] dv, input logic e);
        @(negedge clk);
        crs = c;
        rxd = dv;
        rxer = e;
    endtask

    function automatic logic [7:0] byte_of(input int seed, input int i);
        return 8'((seed * 29 + i * 53 + 7) ^ (i << 3));
    endfunction

    // emode: 0 clean, 1 one error pulse under carrier, 2 pulses only while carrier low
    task automatic send_frame(input int nz, input int npre, input int nb,
                              input int extra, input int emode, input int seed);
        int start;
        int total;
        int epos;
        int k;
        logic [7:0] b;
        start = cap_n;
        total = nz + npre + 1 + 4 * nb + extra;
        epos = (emode == 1) ? (seed % total) : -1;
        k = 0;
        for (int i = 0; i < 2; i++) put(1'b0, 2'b11, emode == 2);
        for (int i = 0; i < nz; i++) begin put(1'b1, 2'b00, k == epos); k++; end
        for (int i = 0; i < npre; i++) begin put(1'b1, 2'b01, k == epos); k++; end
        put(1'b1, 2'b11, k == epos); k++;
        for (int i = 0; i < nb; i++) begin
            b = byte_of(seed, i);
            for (int j = 0; j < 4; j++) begin put(1'b1, b[2*j +: 2], k == epos); k++; end
        end
        for (int i = 0; i < extra; i++) begin put(1'b1, 2'(i + 1), k == epos); k++; end
        put(1'b0, 2'b10, emode == 2);
        put(1'b0, 2'b01, emode == 2);
        put(1'b0, 2'b11, 1'b0);
        put(1'b0, 2'b00, 1'b0);
        chk(cap_n - start == nb, (nb == 0) ? "R6 no-byte frame" : "R2 R4 byte count",
            cap_n - start, nb);
        if (cap_n - start == nb) begin
            for (int i = 0; i < nb; i++) begin
                chk(cap_d[start+i] == byte_of(seed, i), "R3 byte value",
                    cap_d[start+i], byte_of(seed, i));
                chk(cap_l[start+i] == (i == nb - 1), "R5 last flag",
                    cap_l[start+i], i == nb - 1);
                chk(cap_e[start+i] == (i == nb - 1 && emode == 1),
                    (emode == 2) ? "R8 error outside carrier" : "R7 sticky error",
                    cap_e[start+i], i == nb - 1 && emode == 1);
                chk(cap_a[start+i] == (i == nb - 1 && extra != 0), "R6 align error",
                    cap_a[start+i], i == nb - 1 && extra != 0);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int start;
        repeat (3) @(negedge clk);
        chk(ov == 0 && ol == 0 && oe == 0 && oa == 0, "R1 reset outputs", {ov, ol, oe, oa}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ov == 0 && ol == 0 && oe == 0 && oa == 0, "R1 after release", {ov, ol, oe, oa}, 0);

        // R9: garbage dibits and error pulses with carrier low
        start = cap_n;
        for (int i = 0; i < 12; i++) put(1'b0, 2'(i), i[0]);
        put(1'b0, 2'b00, 1'b0);
        chk(cap_n == start, "R9 idle dibits ignored", cap_n - start, 0);

        // R10: carrier without a lock
        start = cap_n;
        for (int i = 0; i < 3; i++) put(1'b1, 2'b00, 1'b0);
        for (int i = 0; i < 5; i++) put(1'b1, 2'b01, 1'b0);
        put(1'b0, 2'b00, 1'b0);
        put(1'b0, 2'b00, 1'b0);
        chk(cap_n == start, "R10 no delimiter", cap_n - start, 0);
        start = cap_n;
        put(1'b1, 2'b01, 1'b0);
        put(1'b1, 2'b01, 1'b0);
        put(1'b1, 2'b10, 1'b0);
        put(1'b1, 2'b11, 1'b0);
        for (int i = 0; i < 8; i++) put(1'b1, 2'b10, 1'b0);
        put(1'b0, 2'b00, 1'b0);
        put(1'b0, 2'b00, 1'b0);
        chk(cap_n == start, "R10 broken delimiter", cap_n - start, 0);

        // Sweep of frame shapes
        for (int nz = 0; nz < 4; nz++)
            for (int np = 1; np < 5; np++)
                for (int nb = 0; nb < 6; nb++)
                    for (int ex = 0; ex < 4; ex++)
                        send_frame(nz, np, nb, ex, (nz + np + nb + ex) % 3,
                                   nz * 97 + np * 31 + nb * 11 + ex);

        // R7: clean frame right after an errored one shows the flag cleared
        send_frame(1, 3, 2, 0, 1, 5);
        send_frame(0, 3, 2, 0, 0, 6);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule